// File: doc/BRIEF.md
# Serial converter target-side framing interface

This block is the device end of a synchronous serial link to a sampling converter. It runs in the serial clock domain. A parallel sample word stands in for the analog core. A host pulls the active-low select line down and clocks the link. In the four-wire mode the block looks for a start marker on the serial input. It then collects a short control word that chooses the input multiplexer setting, and publishes that setting in both raw and decoded form.

Once the control word is in, the block raises a one-cycle convert strobe and captures the parallel sample on that same edge. It then shifts out two low null bits, followed by the sample most-significant bit first. Low bits follow for as long as the host keeps clocking.

In the three-wire mode there is no control word. The first clock with select low starts output at once, and the multiplexer setting is fixed to the one differential pair. A parameter chooses whether the idle serial output floats or is held low.

Top module: `ser_adc_if`

## Requirements
- R1: While `rst` is high, or at any edge where `cs_n` is sampled high, the block returns to idle. From the next edge onward, `dout` is high-impedance (IDLE_HIZ=1) or low (IDLE_HIZ=0), and `conv_strobe`, `cfg_valid`, `pos_sel` and `neg_sel` are 0. Raising `cs_n` in the middle of a transfer aborts it.
- R2: In four-wire mode (`three_wire`=0), `din` is sampled at every rising edge with `cs_n` low. Zeros are skipped. The first 1 is the start bit, and `dout` stays idle until output begins.
- R3: The bit sampled at the edge after the start bit is the single-ended flag and goes to `cfg_single`. The bit at the following edge is the odd/sign flag and goes to `cfg_odd`. `cfg_valid` rises at that second edge and holds, with both flags stable, until `cs_n` goes high.
- R4: Decode. `pos_sel` bit 0 means channel 0 and bit 1 means channel 1. `neg_sel` uses bit 0 for channel 0, bit 1 for channel 1 and bit 2 for ground. When `cfg_single`=1, the positive input is the channel named by `cfg_odd` and the negative input is ground. When `cfg_single`=0 and `cfg_odd`=0, channel 0 is positive and channel 1 is negative. When `cfg_single`=0 and `cfg_odd`=1, channel 1 is positive and channel 0 is negative. Both selects are 0 while `cfg_valid` is 0.
- R5: Two dummy bits follow the flags. At the edge that samples the last dummy bit (edge E), `sample` is captured and `conv_strobe` is high for exactly one cycle. Later changes to `sample` do not alter the output.
- R6: `dout` is driven low after edges E and E+1 (the null bits). After edge E+2+i it carries captured sample bit DATA_W-1-i, for i = 0 to DATA_W-1.
- R7: After the least significant bit, `dout` stays low for every further edge with `cs_n` low.
- R8: Once the control word is complete, `din` has no effect until the next select cycle. In three-wire mode `din` is never used.
- R9: With `three_wire`=1, E is the first edge with `cs_n` low. `cfg_valid` rises at that edge, with `cfg_single`=0 and `cfg_odd`=0.
- R10: Every new low period of `cs_n` starts a new transaction, hunting afresh. `din` activity while `cs_n` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select framing a transaction |
| din | input | 1 | Serial input carrying start bit and control word |
| three_wire | input | 1 | 1 selects the mode without a control word |
| sample | input | DATA_W | Parallel conversion result captured at the strobe edge |
| dout | output | 1 | Serial output: null bits, result MSB first, then zeros |
| conv_strobe | output | 1 | One-cycle pulse at the edge where `sample` is captured |
| cfg_valid | output | 1 | Multiplexer setting is available |
| cfg_single | output | 1 | Raw single-ended flag |
| cfg_odd | output | 1 | Raw odd/sign flag |
| pos_sel | output | 2 | One-hot positive input: channel 0, channel 1 |
| neg_sel | output | 3 | One-hot negative input: channel 0, channel 1, ground |

## Verification
Some rules are checked by the assertions on every cycle. These are the return to idle after a high select, the single-cycle strobe and its tie to a low select, the two null bits that follow the strobe, the stability of the published setting, and the one-hot shape of the decoded selects. The bench scenarios are needed for the rest. They show that leading zeros are skipped and that the flags land in the right fields. They also show that each result bit appears at its exact edge and that the tail stays low. They confirm that `din` after the word, or in three-wire mode, changes nothing, and that the captured sample ignores later changes on `sample`.

// File: rtl/ser_adc_pkg.sv
package ser_adc_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_WORD = 2'd1,
    ST_SEND = 2'd2
  } link_state_e;
endpackage

// File: rtl/ser_adc_ctrl.sv
module ser_adc_ctrl
  import ser_adc_pkg::*;
#(
  parameter int DUMMY_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic din,
  input  logic three_wire,
  output logic launch,
  output logic cfg_valid,
  output logic cfg_single,
  output logic cfg_odd
);
  localparam int WORD_BITS = 2 + DUMMY_BITS;
  localparam int CNT_W     = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);

  link_state_e      state_q;
  logic [CNT_W-1:0] idx_q;

  // launch marks the edge that captures the sample and begins output
  always_comb begin
    launch = 1'b0;
    if (!cs_n) begin
      if (state_q == ST_HUNT && three_wire) launch = 1'b1;
      if (state_q == ST_WORD && idx_q == LAST_IDX) launch = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      state_q    <= ST_HUNT;
      idx_q      <= '0;
      cfg_valid  <= 1'b0;
      cfg_single <= 1'b0;
      cfg_odd    <= 1'b0;
    end else begin
      case (state_q)
        ST_HUNT: begin
          if (three_wire) begin
            state_q    <= ST_SEND;
            cfg_valid  <= 1'b1;
            cfg_single <= 1'b0;
            cfg_odd    <= 1'b0;
          end else if (din) begin
            state_q <= ST_WORD;
            idx_q   <= '0;
          end
        end
        ST_WORD: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == CNT_W'(0)) cfg_single <= din;
          if (idx_q == CNT_W'(1)) begin
            cfg_odd   <= din;
            cfg_valid <= 1'b1;
          end
          if (idx_q == LAST_IDX) state_q <= ST_SEND;
        end
        default: state_q <= ST_SEND;
      endcase
    end
  end
endmodule

// File: rtl/ser_adc_shift.sv
module ser_adc_shift #(
  parameter int DATA_W    = 8,
  parameter int NULL_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] sample,
  output logic              dout_q,
  output logic              dout_oe,
  output logic              conv_strobe
);
  localparam int SH_W = DATA_W + NULL_BITS - 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      sh_q        <= '0;
      dout_q      <= 1'b0;
      dout_oe     <= 1'b0;
      conv_strobe <= 1'b0;
    end else if (launch) begin
      sh_q        <= SH_W'(sample);
      dout_q      <= 1'b0;
      dout_oe     <= 1'b1;
      conv_strobe <= 1'b1;
    end else begin
      conv_strobe <= 1'b0;
      if (dout_oe) begin
        {dout_q, sh_q} <= {sh_q, 1'b0};
      end
    end
  end
endmodule

// File: rtl/ser_adc_muxdec.sv
module ser_adc_muxdec (
  input  logic       cfg_valid,
  input  logic       cfg_single,
  input  logic       cfg_odd,
  output logic [1:0] pos_sel,
  output logic [2:0] neg_sel
);
  always_comb begin
    pos_sel = 2'b00;
    neg_sel = 3'b000;
    if (cfg_valid) begin
      pos_sel = cfg_odd ? 2'b10 : 2'b01;
      if (cfg_single)   neg_sel = 3'b100;
      else if (cfg_odd) neg_sel = 3'b001;
      else              neg_sel = 3'b010;
    end
  end
endmodule

// File: rtl/ser_adc_if.sv
module ser_adc_if #(
  parameter int DATA_W     = 8,
  parameter int NULL_BITS  = 2,
  parameter int DUMMY_BITS = 2,
  parameter bit IDLE_HIZ   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              din,
  input  logic              three_wire,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              conv_strobe,
  output logic              cfg_valid,
  output logic              cfg_single,
  output logic              cfg_odd,
  output logic [1:0]        pos_sel,
  output logic [2:0]        neg_sel
);
  logic launch;
  logic dout_q;
  logic dout_oe;

  ser_adc_ctrl #(.DUMMY_BITS(DUMMY_BITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .din        (din),
    .three_wire (three_wire),
    .launch     (launch),
    .cfg_valid  (cfg_valid),
    .cfg_single (cfg_single),
    .cfg_odd    (cfg_odd)
  );

  ser_adc_shift #(.DATA_W(DATA_W), .NULL_BITS(NULL_BITS)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .launch      (launch),
    .sample      (sample),
    .dout_q      (dout_q),
    .dout_oe     (dout_oe),
    .conv_strobe (conv_strobe)
  );

  ser_adc_muxdec u_dec (
    .cfg_valid  (cfg_valid),
    .cfg_single (cfg_single),
    .cfg_odd    (cfg_odd),
    .pos_sel    (pos_sel),
    .neg_sel    (neg_sel)
  );

  generate
    if (IDLE_HIZ) begin : g_hiz
      assign dout = dout_oe ? dout_q : 1'bz;
    end else begin : g_low
      assign dout = dout_oe & dout_q;
    end
  endgenerate
endmodule

// File: rtl/ser_adc_if_chk.sv
module ser_adc_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       conv_strobe,
  input logic       cfg_valid,
  input logic       cfg_single,
  input logic       cfg_odd,
  input logic [1:0] pos_sel,
  input logic [2:0] neg_sel,
  input logic       dout_q,
  input logic       dout_oe
);
  // R1
  idle_on_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout_oe && !conv_strobe && !cfg_valid));

  // R5
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    conv_strobe |=> !conv_strobe);

  // R5
  strobe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    conv_strobe |-> !$past(cs_n));

  // R6
  first_null_chk: assert property (@(posedge clk) disable iff (rst)
    conv_strobe |-> (dout_oe && !dout_q));

  // R6
  second_null_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_strobe && !cs_n) |=> (dout_oe && !dout_q));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cs_n) |=> (cfg_valid && $stable(cfg_single) && $stable(cfg_odd)));

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> ($countones(pos_sel) == 1 && $countones(neg_sel) == 1 &&
                   neg_sel[2] == cfg_single));

  // R4
  sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |-> (pos_sel == 2'b00 && neg_sel == 3'b000));

  // R4
  diff_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_single) |-> ((pos_sel & neg_sel[1:0]) == 2'b00));
endmodule

bind ser_adc_if ser_adc_if_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .conv_strobe (conv_strobe),
  .cfg_valid   (cfg_valid),
  .cfg_single  (cfg_single),
  .cfg_odd     (cfg_odd),
  .pos_sel     (pos_sel),
  .neg_sel     (neg_sel),
  .dout_q      (dout_q),
  .dout_oe     (dout_oe)
);

// File: tb/test_ser_adc_if.sv
module test_ser_adc_if;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          din = 1'b0;
  logic          three_wire = 1'b0;
  logic [DW-1:0] sample = '0;
  logic          dout;
  logic          conv_strobe;
  logic          cfg_valid;
  logic          cfg_single;
  logic          cfg_odd;
  logic [1:0]    pos_sel;
  logic [2:0]    neg_sel;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ser_adc_if #(.DATA_W(DW)) i_ser_adc_if (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .din         (din),
    .three_wire  (three_wire),
    .sample      (sample),
    .dout        (dout),
    .conv_strobe (conv_strobe),
    .cfg_valid   (cfg_valid),
    .cfg_single  (cfg_single),
    .cfg_odd     (cfg_odd),
    .pos_sel     (pos_sel),
    .neg_sel     (neg_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_dout(input int k, input int e, input logic [DW-1:0] s);
    if (k < e) return 1'bz;
    if (k < e + 2) return 1'b0;
    if (k < e + 2 + DW) return s[DW - 1 - (k - e - 2)];
    return 1'b0;
  endfunction

  function automatic logic [1:0] exp_pos(input logic sgl, input logic odd);
    return odd ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [2:0] exp_neg(input logic sgl, input logic odd);
    if (sgl) return 3'b100;
    return odd ? 3'b001 : 3'b010;
  endfunction

  task automatic idle_check(input string req);
    chk({req, " dout"}, {7'd0, dout}, {7'd0, 1'bz});
    chk({req, " strobe"}, {7'd0, conv_strobe}, 8'd0);
    chk({req, " valid"}, {7'd0, cfg_valid}, 8'd0);
    chk({req, " sel"}, {3'd0, pos_sel, neg_sel}, 8'd0);
  endtask

  // One select cycle of n edges, then select high with din toggling (R10).
  task automatic run_txn(input bit tw, input int lead, input logic [DW-1:0] smp,
                         input logic sgl, input logic odd, input int n);
    int e;
    logic esgl, eodd;
    e    = tw ? 0 : lead + 4;
    esgl = tw ? 1'b0 : sgl;
    eodd = tw ? 1'b0 : odd;
    for (int k = 0; k < n; k++) begin
      string lbl;
      @(negedge clk);
      cs_n       = 1'b0;
      three_wire = tw;
      if (tw)                din = 1'($urandom);  // R8: unused in three-wire mode
      else if (k < lead)     din = 1'b0;
      else if (k == lead)    din = 1'b1;
      else if (k == lead+1)  din = sgl;
      else if (k == lead+2)  din = odd;
      else                   din = 1'($urandom);  // R8: dummy bits and beyond
      sample = (k <= e) ? smp : DW'($urandom);    // R5: later changes ignored
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (k < e)              lbl = "R2/R10 dout";
      else if (k < e + 2 + DW) lbl = "R6/R8 dout";
      else                     lbl = "R7 dout";
      chk(lbl, {7'd0, dout}, {7'd0, exp_dout(k, e, smp)});
      chk("R5 strobe", {7'd0, conv_strobe}, {7'd0, (k == e)});
      if (tw || k >= lead + 2) begin
        chk(tw ? "R9 valid" : "R3 valid", {7'd0, cfg_valid}, 8'd1);
        chk(tw ? "R9 cfg" : "R3 cfg", {6'd0, cfg_single, cfg_odd}, {6'd0, esgl, eodd});
        chk("R4 sel", {3'd0, pos_sel, neg_sel}, {3'd0, exp_pos(esgl, eodd), exp_neg(esgl, eodd)});
      end else begin
        chk("R3 not yet valid", {7'd0, cfg_valid}, 8'd0);
      end
    end
    @(negedge clk);
    cs_n = 1'b1;
    din  = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    idle_check("R1 after select high");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    idle_check("R1 reset");

    // Directed corners
    run_txn(1'b0, 0, 8'hA5, 1'b1, 1'b0, 4 + 2 + DW + 2);
    run_txn(1'b0, 5, 8'h80, 1'b0, 1'b1, 9 + 2 + DW + 3);
    run_txn(1'b0, 2, 8'hFF, 1'b1, 1'b1, 6 + 2 + DW + 1);
    run_txn(1'b0, 1, 8'h01, 1'b0, 1'b0, 5 + 2 + DW + 12);  // R7 long tail
    run_txn(1'b1, 0, 8'h3C, 1'b1, 1'b1, 2 + DW + 4);       // R9
    run_txn(1'b0, 3, 8'hC3, 1'b1, 1'b0, 7 + 4);            // R1 abort mid-data
    run_txn(1'b0, 4, 8'h5A, 1'b0, 1'b1, 2);                // R1 abort while hunting
    run_txn(1'b1, 0, 8'h96, 1'b0, 1'b0, 1);                // R1 abort three-wire

    // Constrained random transactions
    for (int t = 0; t < 60; t++) begin
      bit tw;
      int lead, n;
      tw   = ($urandom % 4) == 0;
      lead = int'($urandom % 7);
      n    = (tw ? 0 : lead + 4) + 2 + DW + int'($urandom % 5);
      if (($urandom % 8) == 0) n = 1 + int'($urandom % 12);
      run_txn(tw, lead, DW'($urandom), 1'($urandom), 1'($urandom), n);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule